// File: doc/BRIEF.md
# Processor Interrupt Level Arbiter

This block sits beside a processor core and decides, every clock, which interrupt request the core should see. It merges a vector of external level inputs with the software-interrupt register. It folds the two timer-match bits of that register into level 14. It then picks the highest pending level above the current processor interrupt level and presents a request line together with the 9-bit trap type the core should take.

A separate vectored-interrupt path has a single slot. A raise strobe with a 6-bit source number fills three data words, sets a busy flag and forces the vectored trap type. While busy, that path overrides every level. A lower strobe releases it.

The block also guards against nesting. While the core is already inside an external-interrupt trap of a higher type, a lower candidate is not allowed to change the held request.

The vector strobe is a plain event pin rather than a valid/ready stream. The block never applies back-pressure. A raise that arrives while the slot is busy is dropped, and a lower that arrives while the slot is idle is dropped. The source must keep the slot protocol itself.

Top module: `pil_arbiter`

## Requirements
- R1: The pending vector is formed per level n (1..15) as ext_lvl[n] OR sw_int[n]. Bits 0 and 16 of sw_int (the two timer-match bits) never act as levels 0 or 16, and level 0 is never pending.
- R2: If sw_int[0] or sw_int[16] is set, level 14 is pending.
- R3: While vec_busy is 1 and no lower strobe is taken, irq_req stays 1 and irq_tt stays 0x060, whatever the levels, pil, int_en or trap inputs are.
- R4: When not busy, with int_en set and no suppression, the highest pending level L with L > pil gives irq_req=1 and irq_tt=0x040|L on the clock edge after the inputs are applied.
- R5: When not busy and no pending level lies above pil, the next edge gives irq_req=0 and irq_tt=0.
- R6: When not busy and int_en is 0, the next edge gives irq_req=0 and irq_tt=0.
- R7: When not busy, with trap_lvl nonzero, (cur_tt & 0x1F0)==0x040 and cur_tt greater than the candidate type 0x040|L, irq_req and irq_tt keep their previous values.
- R8: A raise (vec_strobe=1, vec_raise=1) while vec_busy=0 sets vec_busy, vec_w0=0x7C0|vec_src, vec_w1=vec_w2=0, irq_req=1 and irq_tt=0x060 on the next edge. A raise while busy changes nothing.
- R9: A lower (vec_strobe=1, vec_raise=0) while busy clears vec_busy and gives irq_req=0 and irq_tt=0 on the next edge. A lower while idle is ignored and level arbitration proceeds as usual.
- R10: Synchronous reset (rst=1) clears irq_req, irq_tt, vec_busy and all three data words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_lvl | input | 15 | External interrupt levels 15..1 |
| sw_int | input | 17 | Software-interrupt register: bits 15..1 levels, bit 0 and bit 16 timer matches |
| pil | input | 4 | Current processor interrupt level |
| int_en | input | 1 | Global interrupt enable |
| trap_lvl | input | 3 | Current trap level |
| cur_tt | input | 9 | Trap type at the current trap level |
| vec_strobe | input | 1 | Vectored-interrupt event strobe |
| vec_raise | input | 1 | 1 = raise, 0 = lower (valid with vec_strobe) |
| vec_src | input | 6 | Vectored-interrupt source number |
| irq_req | output | 1 | Registered interrupt request |
| irq_tt | output | 9 | Trap type of the presented request, 0 when idle |
| vec_busy | output | 1 | Vectored-interrupt slot occupied |
| vec_w0 | output | 64 | Vector data word 0 |
| vec_w1 | output | 64 | Vector data word 1 |
| vec_w2 | output | 64 | Vector data word 2 |

## Verification
The level function is swept over every pil value. Each level 1..15 is driven alone, first through the external inputs and then through the software register, which separates a wrong threshold compare from a wrong source merge. Pairs of levels across both sources then confirm that the highest one wins rather than the lowest or the last. The timer bits are driven alone at every pil to tell level-14 folding apart from a literal bit-0 or bit-16 merge. The nesting guard is swept over current trap types just below, inside and above the external range against every candidate, so off-by-one errors in the mask and in the comparison show up as a changed or held type. All 64 vector sources run through the raise, duplicate-raise, hold, lower and stray-lower sequence.

// File: rtl/pil_arb_pkg.sv
package pil_arb_pkg;
  // width of a trap type and fixed trap-type codes
  localparam int TT_W = 9;
  localparam logic [TT_W-1:0] EXT_BASE_TT = 9'h040;
  localparam logic [TT_W-1:0] VEC_TT      = 9'h060;
  // prefix placed above the source number in vector word 0
  localparam logic [10:0] VEC_W0_TAG = 11'h7C0;
endpackage

// File: rtl/pil_lvl_merge.sv
module pil_lvl_merge #(
  parameter int NUM_LVL   = 16,
  parameter int TIMER_LVL = 14
) (
  input  logic [NUM_LVL-1:1] ext_lvl,
  input  logic [NUM_LVL:0]   sw_int,
  output logic [NUM_LVL-1:0] pend
);
  logic timer_hit;
  assign timer_hit = sw_int[0] | sw_int[NUM_LVL];
  assign pend[0]   = 1'b0;

  for (genvar g = 1; g < NUM_LVL; g++) begin : g_lvl
    if (g == TIMER_LVL) begin : g_tmr
      assign pend[g] = ext_lvl[g] | sw_int[g] | timer_hit;
    end else begin : g_plain
      assign pend[g] = ext_lvl[g] | sw_int[g];
    end
  end
endmodule

// File: rtl/pil_lvl_pick.sv
module pil_lvl_pick #(
  parameter int NUM_LVL = 16,
  localparam int LVL_W  = $clog2(NUM_LVL)
) (
  input  logic [NUM_LVL-1:0] pend,
  input  logic [LVL_W-1:0]   pil,
  output logic               found,
  output logic [LVL_W-1:0]   lvl
);
  // ascending scan: the last qualifying level written is the highest
  always_comb begin
    found = 1'b0;
    lvl   = '0;
    for (int i = 1; i < NUM_LVL; i++) begin
      if (pend[i] && (i > int'(pil))) begin
        found = 1'b1;
        lvl   = LVL_W'(i);
      end
    end
  end
endmodule

// File: rtl/pil_vec_slot.sv
module pil_vec_slot
  import pil_arb_pkg::*;
#(
  parameter int SRC_W  = 6,
  parameter int WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic              raise,
  input  logic [SRC_W-1:0]  src,
  output logic              take_raise,
  output logic              take_lower,
  output logic              busy,
  output logic [WORD_W-1:0] w0,
  output logic [WORD_W-1:0] w1,
  output logic [WORD_W-1:0] w2
);
  assign take_raise = strobe &  raise & ~busy;
  assign take_lower = strobe & ~raise &  busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      w0   <= '0;
      w1   <= '0;
      w2   <= '0;
    end else if (take_raise) begin
      busy <= 1'b1;
      w0   <= WORD_W'(VEC_W0_TAG) | WORD_W'(src);
      w1   <= '0;
      w2   <= '0;
    end else if (take_lower) begin
      busy <= 1'b0;
    end
  end

  a_r9_lower_frees: assert property (@(posedge clk) disable iff (rst)
    (strobe && !raise && busy) |=> !busy);
  a_r8_words_clear: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (w1 == '0 && w2 == '0));
  a_r8_dup_raise: assert property (@(posedge clk) disable iff (rst)
    (strobe && raise && busy) |=> (busy && $stable(w0)));
endmodule

// File: rtl/pil_arbiter.sv
module pil_arbiter
  import pil_arb_pkg::*;
#(
  parameter int NUM_LVL   = 16,
  parameter int TIMER_LVL = 14,
  parameter int TL_W      = 3,
  parameter int SRC_W     = 6,
  parameter int WORD_W    = 64,
  localparam int LVL_W    = $clog2(NUM_LVL)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_LVL-1:1] ext_lvl,
  input  logic [NUM_LVL:0]  sw_int,
  input  logic [LVL_W-1:0]  pil,
  input  logic              int_en,
  input  logic [TL_W-1:0]   trap_lvl,
  input  logic [TT_W-1:0]   cur_tt,
  input  logic              vec_strobe,
  input  logic              vec_raise,
  input  logic [SRC_W-1:0]  vec_src,
  output logic              irq_req,
  output logic [TT_W-1:0]   irq_tt,
  output logic              vec_busy,
  output logic [WORD_W-1:0] vec_w0,
  output logic [WORD_W-1:0] vec_w1,
  output logic [WORD_W-1:0] vec_w2
);
  logic [NUM_LVL-1:0] pend;
  logic               found;
  logic [LVL_W-1:0]   pick_lvl;
  logic               take_raise, take_lower;
  logic [TT_W-1:0]    cand_tt;
  logic               nest_block;

  pil_lvl_merge #(.NUM_LVL(NUM_LVL), .TIMER_LVL(TIMER_LVL)) u_merge (
    .ext_lvl(ext_lvl), .sw_int(sw_int), .pend(pend)
  );

  pil_lvl_pick #(.NUM_LVL(NUM_LVL)) u_pick (
    .pend(pend), .pil(pil), .found(found), .lvl(pick_lvl)
  );

  pil_vec_slot #(.SRC_W(SRC_W), .WORD_W(WORD_W)) u_vec (
    .clk(clk), .rst(rst), .strobe(vec_strobe), .raise(vec_raise),
    .src(vec_src), .take_raise(take_raise), .take_lower(take_lower),
    .busy(vec_busy), .w0(vec_w0), .w1(vec_w1), .w2(vec_w2)
  );

  assign cand_tt    = EXT_BASE_TT | TT_W'(pick_lvl);
  // already inside a higher external-interrupt trap: keep what is held
  assign nest_block = (|trap_lvl)
                    && (cur_tt[TT_W-1:4] == EXT_BASE_TT[TT_W-1:4])
                    && (cur_tt > cand_tt);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      irq_tt  <= '0;
    end else if (take_raise) begin
      irq_req <= 1'b1;
      irq_tt  <= VEC_TT;
    end else if (take_lower) begin
      irq_req <= 1'b0;
      irq_tt  <= '0;
    end else if (vec_busy) begin
      irq_req <= irq_req;
    end else if (!found || !int_en) begin
      irq_req <= 1'b0;
      irq_tt  <= '0;
    end else if (!nest_block) begin
      irq_req <= 1'b1;
      irq_tt  <= cand_tt;
    end
  end

  a_r5_idle_tt_zero: assert property (@(posedge clk) disable iff (rst)
    !irq_req |-> (irq_tt == '0));
  a_r4_tt_kind: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> ((irq_tt == VEC_TT) ||
                 ((irq_tt[TT_W-1:4] == EXT_BASE_TT[TT_W-1:4]) && (irq_tt[3:0] != 4'd0))));
  a_r6_disabled: assert property (@(posedge clk) disable iff (rst)
    (!int_en && !vec_busy && !vec_strobe) |=> !irq_req);
  a_r8_raise: assert property (@(posedge clk) disable iff (rst)
    (vec_strobe && vec_raise && !vec_busy) |=> (vec_busy && irq_req && irq_tt == VEC_TT));
  a_r3_vec_wins: assert property (@(posedge clk) disable iff (rst)
    (vec_busy && !(vec_strobe && !vec_raise)) |=> (irq_req && irq_tt == VEC_TT));
  a_r9_lower_drops: assert property (@(posedge clk) disable iff (rst)
    (vec_strobe && !vec_raise && vec_busy) |=> (!irq_req && irq_tt == '0));
endmodule

// File: tb/test_pil_arbiter.sv
`timescale 1ns/1ps
module test_pil_arbiter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:1] ext_lvl = '0;
  logic [16:0] sw_int = '0;
  logic [3:0]  pil = '0;
  logic        int_en = 1'b0;
  logic [2:0]  trap_lvl = '0;
  logic [8:0]  cur_tt = '0;
  logic        vec_strobe = 1'b0, vec_raise = 1'b0;
  logic [5:0]  vec_src = '0;
  logic        irq_req, vec_busy;
  logic [8:0]  irq_tt;
  logic [63:0] vec_w0, vec_w1, vec_w2;

  // expected state, kept by the bench from the requirements
  logic        e_req = 1'b0, e_busy = 1'b0;
  logic [8:0]  e_tt = '0;
  logic [63:0] e_w0 = '0, e_w1 = '0, e_w2 = '0;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pil_arbiter i_pil_arbiter (
    .clk(clk), .rst(rst), .ext_lvl(ext_lvl), .sw_int(sw_int), .pil(pil),
    .int_en(int_en), .trap_lvl(trap_lvl), .cur_tt(cur_tt),
    .vec_strobe(vec_strobe), .vec_raise(vec_raise), .vec_src(vec_src),
    .irq_req(irq_req), .irq_tt(irq_tt), .vec_busy(vec_busy),
    .vec_w0(vec_w0), .vec_w1(vec_w1), .vec_w2(vec_w2)
  );

  task automatic model();
    logic [15:0] p;
    int top;
    p = '0;
    for (int i = 1; i < 16; i++) p[i] = ext_lvl[i] | sw_int[i];
    if (sw_int[0] || sw_int[16]) p[14] = 1'b1;
    top = 0;
    for (int i = 15; i > int'(pil); i--) if (p[i] && top == 0) top = i;
    if (rst) begin
      e_req = 0; e_tt = 0; e_busy = 0; e_w0 = 0; e_w1 = 0; e_w2 = 0;
    end else if (vec_strobe && vec_raise && !e_busy) begin
      e_busy = 1; e_w0 = 64'h7C0 + 64'(vec_src); e_w1 = 0; e_w2 = 0;
      e_req = 1; e_tt = 9'h060;
    end else if (vec_strobe && !vec_raise && e_busy) begin
      e_busy = 0; e_req = 0; e_tt = 0;
    end else if (e_busy) begin
      // vector holds
    end else if (top == 0 || !int_en) begin
      e_req = 0; e_tt = 0;
    end else if (trap_lvl != 0 && (cur_tt & 9'h1F0) == 9'h040 && cur_tt > 9'(9'h040 + top)) begin
      // nesting guard keeps old values
    end else begin
      e_req = 1; e_tt = 9'(9'h040 + top);
    end
  endtask

  task automatic chk(string tag, string what, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
    end
  endtask

  task automatic cyc(string tag);
    @(posedge clk);
    model();
    @(negedge clk);
    chk(tag, "irq_req", 64'(irq_req), 64'(e_req));
    chk(tag, "irq_tt", 64'(irq_tt), 64'(e_tt));
    chk(tag, "vec_busy", 64'(vec_busy), 64'(e_busy));
    chk(tag, "vec_w0", vec_w0, e_w0);
    chk(tag, "vec_w1", vec_w1, e_w1);
    chk(tag, "vec_w2", vec_w2, e_w2);
  endtask

  task automatic clr();
    ext_lvl = '0; sw_int = '0; pil = '0; int_en = 1'b1;
    trap_lvl = '0; cur_tt = '0; vec_strobe = 0; vec_raise = 0; vec_src = '0;
  endtask

  initial begin
    repeat (2) cyc("R10");
    rst = 1'b0;
    clr();
    // R4 / R5: single external level at every pil
    for (int p = 0; p < 16; p++)
      for (int l = 1; l < 16; l++) begin
        ext_lvl = '0; ext_lvl[l] = 1'b1; pil = 4'(p);
        cyc(l > p ? "R4" : "R5");
      end
    ext_lvl = '0;
    // R1: single software level at every pil
    for (int p = 0; p < 16; p++)
      for (int l = 1; l < 16; l++) begin
        sw_int = '0; sw_int[l] = 1'b1; pil = 4'(p);
        cyc("R1");
      end
    // R2: timer-match bits alone fold into level 14
    for (int p = 0; p < 16; p++) begin
      pil = 4'(p);
      sw_int = 17'h00001; cyc("R2");
      sw_int = 17'h10000; cyc("R2");
      sw_int = '0; cyc("R5");
    end
    // R4: two levels from different sources, highest must win
    for (int p = 0; p < 16; p += 7)
      for (int i = 1; i < 16; i++)
        for (int j = 1; j < 16; j++) begin
          clr(); pil = 4'(p); ext_lvl[i] = 1'b1; sw_int[j] = 1'b1;
          cyc("R4");
        end
    // R6: global disable drops an active request
    for (int l = 1; l < 16; l++) begin
      clr(); ext_lvl[l] = 1'b1; cyc("R4");
      int_en = 1'b0; cyc("R6");
    end
    // R7: nesting guard over trap types around the external range
    for (int ct = 9'h030; ct < 9'h060; ct++)
      for (int l = 1; l < 16; l++) begin
        clr(); ext_lvl[1] = 1'b1; cyc("R4");
        trap_lvl = 3'd1; cur_tt = 9'(ct); ext_lvl = '0; ext_lvl[l] = 1'b1;
        cyc("R7");
        trap_lvl = 3'd0; cyc("R7");
      end
    // R8 / R3 / R9: vectored path for every source
    for (int s = 0; s < 64; s++) begin
      clr(); ext_lvl[3] = 1'b1; cyc("R4");
      vec_strobe = 1; vec_raise = 1; vec_src = 6'(s); cyc("R8");
      vec_strobe = 0; ext_lvl = '1; int_en = 1'b0; cyc("R3");
      int_en = 1'b1; pil = 4'd2; trap_lvl = 3'd2; cur_tt = 9'h04F; cyc("R3");
      vec_strobe = 1; vec_raise = 1; vec_src = 6'(s ^ 6'h2A); cyc("R8");
      vec_raise = 0; cyc("R9");
      clr(); ext_lvl[5] = 1'b1; vec_strobe = 1; vec_raise = 0; cyc("R9");
    end
    // R10: reset while the vector slot is busy
    clr(); vec_strobe = 1; vec_raise = 1; vec_src = 6'h15; cyc("R8");
    vec_strobe = 0; rst = 1'b1; cyc("R10");
    rst = 1'b0; cyc("R5");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R10 got=timeout exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule